// File: doc/BRIEF.md
# USB Downstream Port Attach/Detach Qualifier

This block watches the two single-ended receiver levels of one downstream USB port. Both levels arrive already synchronised to a free-running reference clock. It decides when a device has been plugged in, which speed class the device belongs to, and when the device has gone away. A device announces itself by pulling one data line high. A high D+ means a full-speed or high-speed device, and a high D- means a low-speed device. The block only reports an attach once that idle level has held without a break for the whole attach debounce window.

A removal shows up as both lines sitting low (SE0). The block reports a detach once SE0 has lasted for the detach window. That window is shorter than the attach window and is set by its own parameter. While the host itself drives the port, for example during reset or resume signalling, SE0 is expected on the lines, so detach qualification is held off.

The outputs are a connect level, a low-speed flag, and a sticky change flag. The change flag is set on every change of connect status and is cleared by a write-one-to-clear strobe.

Top module: `usb_attach_detect`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `connected`, `low_speed` and `conn_change` are 0.
- R2: While disconnected, D+=1 and D-=0 sampled on ATTACH_CYC consecutive rising edges sets `connected` at the last of those edges, with `low_speed`=0.
- R3: While disconnected, D+=0 and D-=1 sampled on ATTACH_CYC consecutive rising edges sets `connected` with `low_speed`=1. `low_speed` is never 1 while `connected` is 0, and it does not change while connected.
- R4: Any sampled edge with a non-qualifying line state (SE0 or both lines high) during the attach window restarts the window from zero.
- R5: A switch between the two attach line states during the window restarts the window. The speed class reported is the one that held for the full window.
- R6: While connected and `host_drive`=0, SE0 sampled on DETACH_CYC consecutive rising edges clears `connected` and `low_speed` at the last of those edges.
- R7: Any non-SE0 sample during the detach window restarts that window.
- R8: A sample with `host_drive`=1 never counts toward detach and restarts the detach window.
- R9: `conn_change` is set on the edge at which `connected` changes, in either direction, and stays set until cleared.
- R10: `chg_clr`=1 sampled at an edge clears `conn_change`, unless `connected` changes at that same edge; in that case the flag stays set.
- R11: Attach line states have no effect while connected, and SE0 has no effect while disconnected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock (48 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| dp | input | 1 | Synchronised D+ single-ended level |
| dm | input | 1 | Synchronised D- single-ended level |
| host_drive | input | 1 | High while the host drives the port; masks detach |
| chg_clr | input | 1 | Write-one-to-clear strobe for `conn_change` |
| connected | output | 1 | Current connect status |
| low_speed | output | 1 | 1 when the attached device is low-speed |
| conn_change | output | 1 | Sticky connect-status-change flag |

## Verification
The bench builds the block with its default windows: ATTACH_CYC=120, which is 2.5 us at 48 MHz, and DETACH_CYC=108, which is 2.25 us. At these values every window can be driven to exactly one cycle short of its limit, broken, and then completed, so the restart rules of both windows are tested at their exact boundaries. They also make the asymmetry between the two windows observable, and they let the bench place a clear strobe on the same edge as a detach.

// File: rtl/usb_attach_detect.sv
module usb_attach_detect #(
  parameter int ATTACH_CYC = 120,
  parameter int DETACH_CYC = 108
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp,
  input  logic dm,
  input  logic host_drive,
  input  logic chg_clr,
  output logic connected,
  output logic low_speed,
  output logic conn_change
);
  localparam int MAXW = (ATTACH_CYC > DETACH_CYC) ? ATTACH_CYC : DETACH_CYC;
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [CW-1:0] ATT_LAST = CW'(ATTACH_CYC - 1);
  localparam logic [CW-1:0] DET_LAST = CW'(DETACH_CYC - 1);

  logic [CW-1:0] cnt;
  logic [1:0]    cand;

  wire [1:0] cls    = {dm & ~dp, dp & ~dm};
  wire       det_ok = ~dp & ~dm & ~host_drive;
  wire       att_go = (cls != 2'b00) && (cnt == '0 || cls == cand);
  wire       att_hit = att_go && cnt == ATT_LAST;
  wire       det_hit = det_ok && cnt == DET_LAST;
  wire       flip   = connected ? det_hit : att_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      connected   <= 1'b0;
      low_speed   <= 1'b0;
      conn_change <= 1'b0;
      cnt         <= '0;
      cand        <= 2'b00;
    end else begin
      conn_change <= flip | (conn_change & ~chg_clr);
      if (!connected) begin
        if (att_hit) begin
          connected <= 1'b1;
          low_speed <= cls[1];
          cnt       <= '0;
        end else if (att_go) begin
          cnt  <= cnt + 1'b1;
          cand <= cls;
        end else if (cls != 2'b00) begin
          cnt  <= CW'(1);
          cand <= cls;
        end else begin
          cnt <= '0;
        end
      end else begin
        if (det_hit) begin
          connected <= 1'b0;
          low_speed <= 1'b0;
          cnt       <= '0;
        end else if (det_ok) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/usb_attach_detect_chk.sv
module usb_attach_detect_chk #(
  parameter int ATTACH_CYC = 120,
  parameter int DETACH_CYC = 108
) (
  input logic clk,
  input logic rst_n,
  input logic dp,
  input logic dm,
  input logic host_drive,
  input logic chg_clr,
  input logic connected,
  input logic low_speed,
  input logic conn_change
);
  int att_len;
  int det_len;
  logic [1:0] pcls;
  wire [1:0] lcls = {dm & ~dp, dp & ~dm};
  wire       lse0 = ~dp & ~dm & ~host_drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      att_len <= 0;
      det_len <= 0;
      pcls    <= 2'b00;
    end else begin
      pcls <= lcls;
      if (lcls == 2'b00) att_len <= 0;
      else if (lcls == pcls) att_len <= (att_len < ATTACH_CYC) ? att_len + 1 : att_len;
      else att_len <= 1;
      if (!lse0) det_len <= 0;
      else det_len <= (det_len < DETACH_CYC) ? det_len + 1 : det_len;
    end
  end

  assert_attach_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connected) |-> att_len >= ATTACH_CYC);
  assert_ls_needs_conn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_speed |-> connected);
  assert_speed_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    connected && $past(connected) |-> $stable(low_speed));
  assert_detach_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connected) |-> det_len >= DETACH_CYC);
  assert_detach_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connected) |-> !$past(host_drive));
  assert_change_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connected) || $fell(connected) |-> conn_change);
  assert_change_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conn_change) && !$past(chg_clr) |-> conn_change);
endmodule

bind usb_attach_detect usb_attach_detect_chk #(
  .ATTACH_CYC(ATTACH_CYC), .DETACH_CYC(DETACH_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .host_drive(host_drive),
  .chg_clr(chg_clr), .connected(connected), .low_speed(low_speed),
  .conn_change(conn_change)
);

// File: tb/usb_attach_detect_tb.sv
module usb_attach_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b0, host_drive = 1'b0, chg_clr = 1'b0;
  logic connected, low_speed, conn_change;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  usb_attach_detect #(.ATTACH_CYC(120), .DETACH_CYC(108)) u_dut (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .host_drive(host_drive),
    .chg_clr(chg_clr), .connected(connected), .low_speed(low_speed),
    .conn_change(conn_change)
  );

  // {dp, dm, host_drive, cycles[11:0], exp_connected, exp_low_speed}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {3'b100, 12'd119, 2'b00},  // R2 one short
    {3'b000, 12'd1,   2'b00},  // R4 break
    {3'b100, 12'd119, 2'b00},  // R4 restarted
    {3'b100, 12'd1,   2'b10},  // R2 full window
    {3'b000, 12'd107, 2'b10},  // R6 one short
    {3'b100, 12'd1,   2'b10},  // R7 break
    {3'b000, 12'd107, 2'b10},  // R7 restarted
    {3'b001, 12'd50,  2'b10},  // R8 masked
    {3'b000, 12'd107, 2'b10},  // R8 window restarted
    {3'b000, 12'd1,   2'b00},  // R6 detach
    {3'b010, 12'd60,  2'b00},  // R5 low-speed start
    {3'b100, 12'd60,  2'b00},  // R5 class switch
    {3'b110, 12'd10,  2'b00},  // R4 both high
    {3'b010, 12'd120, 2'b11},  // R3 low-speed attach
    {3'b100, 12'd200, 2'b11},  // R11 ignored while connected
    {3'b000, 12'd108, 2'b00},  // R6 detach clears speed
    {3'b000, 12'd500, 2'b00}   // R11 SE0 idle while disconnected
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic hold(input logic p, input logic m, input logic h, input int n);
    dp = p; dm = m; host_drive = h;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic exp_chg;
    logic prev_conn;
    repeat (3) @(negedge clk);
    check("R1 connected", connected, 1'b0);
    check("R1 low_speed", low_speed, 1'b0);
    check("R1 conn_change", conn_change, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", connected | low_speed | conn_change, 1'b0);

    exp_chg = 1'b0;
    prev_conn = 1'b0;
    for (int i = 0; i < NV; i++) begin
      hold(VEC[i][16], VEC[i][15], VEC[i][14], int'(VEC[i][13:2]));
      if (VEC[i][1] != prev_conn) exp_chg = 1'b1;
      prev_conn = VEC[i][1];
      check($sformatf("R2-table vec%0d connected", i), connected, VEC[i][1]);
      check($sformatf("R3 vec%0d low_speed", i), low_speed, VEC[i][0]);
      check($sformatf("R9 vec%0d conn_change", i), conn_change, exp_chg);
    end

    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
    check("R10 clear", conn_change, 1'b0);
    hold(1'b0, 1'b1, 1'b0, 119);
    check("R9 flag quiet before attach", conn_change, 1'b0);
    hold(1'b0, 1'b1, 1'b0, 1);
    check("R9 set on attach", conn_change, 1'b1);
    check("R3 low-speed attach", low_speed, 1'b1);
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
    check("R10 clear while connected", conn_change, 1'b0);
    hold(1'b0, 1'b0, 1'b0, 107);
    check("R6 still connected", connected, 1'b1);
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
    check("R6 detach at window end", connected, 1'b0);
    check("R10 set wins over clear", conn_change, 1'b1);
    hold(1'b1, 1'b0, 1'b0, 120);
    check("R2 reattach", connected, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset while connected", connected | low_speed | conn_change, 1'b0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule